// File: doc/BRIEF.md
# Ring-Count Pickup Controller

This block decides when a call-answering recorder should take a line. It watches a stream of single-cycle pulses, one at the close of every ring, and counts them. Once the count reaches the threshold picked by a select input (a short threshold or a long one), it raises a pickup command. The command stays up until the line reports that the call is answered. An answered indication at any moment, whether it comes from a person lifting the handset during the count or from the recorder itself, sends the controller back to its idle state with no rings counted.

The machine is Moore style, so the pickup command is decoded from registered state only. It therefore appears on the cycle after the edge that samples the qualifying ring pulse. The two thresholds are parameters; the defaults are two and four rings. The select input must stay steady while rings are being counted.

Top module: `ring_answer_ctrl`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a rising clock edge, the next state is idle with zero rings counted, and `pickup` is 0 in the following cycle.
- R2: With `sel_long`=0, `pickup` rises in the cycle after the edge that samples the SHORT_RINGS-th (default second) `ring_end` pulse since idle, and stays 0 before then.
- R3: With `sel_long`=1, `pickup` rises in the cycle after the edge that samples the LONG_RINGS-th (default fourth) `ring_end` pulse since idle, and stays 0 before then.
- R4: Once `pickup` is 1, it stays 1 for as long as `answered` is 0, and further `ring_end` pulses have no effect on it.
- R5: An `answered` value of 1 sampled at any edge sends the machine to idle with zero rings counted. `pickup` is 0 in the next cycle, and the following ring counts as the first.
- R6: When `ring_end` and `answered` are both 1 at the same edge, `answered` wins. That ring is not counted.
- R7: `pickup` is a function of registered state alone. It rises only in a cycle that follows an edge at which `ring_end` was 1 and `answered` was 0.
- R8: Cycles in which `ring_end` and `answered` are both 0 leave the ring count and `pickup` unchanged, so gaps between rings of any length are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ring_end | input | 1 | One-cycle pulse at the close of each ring |
| answered | input | 1 | High when the line has been answered |
| sel_long | input | 1 | 0: SHORT_RINGS threshold, 1: LONG_RINGS threshold |
| pickup | output | 1 | Command for the recorder to answer the line |

## Verification
The bench builds the block with its default thresholds of two and four rings. This keeps both the short and the long sequences within a few dozen cycles, so gaps between rings, a mid-count answer, and an answer arriving together with a ring can all be exercised for each threshold. A behavioural ring counter in the bench predicts `pickup` and is compared on every clock. This also covers the one-cycle Moore delay after each qualifying ring.

// File: rtl/ans_pkg.sv
package ans_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_COUNT = 2'd1,
        PH_OFFER = 2'd2
    } phase_e;

endpackage

// File: rtl/ring_tally.sv
module ring_tally
    import ans_pkg::*;
#(
    parameter int SHORT_RINGS = 2,
    parameter int LONG_RINGS  = 4,
    parameter int CW          = $clog2(LONG_RINGS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase_q,
    input  logic [CW-1:0] rings_q,
    input  logic          ring_end,
    input  logic          answered,
    input  logic          sel_long,
    output phase_e        phase_d,
    output logic [CW-1:0] rings_d
);

    localparam logic [CW-1:0] SHORT_T = CW'(SHORT_RINGS);
    localparam logic [CW-1:0] LONG_T  = CW'(LONG_RINGS);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] rings;
    } tally_t;

    tally_t        nxt_d;
    logic [CW-1:0] target;
    logic [CW-1:0] bumped;

    always_comb begin
        target = sel_long ? LONG_T : SHORT_T;
        bumped = rings_q + CW'(1);
        nxt_d.phase = phase_q;
        nxt_d.rings = rings_q;
        if (answered) begin
            nxt_d.phase = PH_IDLE;
            nxt_d.rings = '0;
        end else begin
            unique case (phase_q)
                PH_IDLE, PH_COUNT: begin
                    if (ring_end) begin
                        nxt_d.rings = bumped;
                        nxt_d.phase = (bumped >= target) ? PH_OFFER : PH_COUNT;
                    end
                end
                PH_OFFER: begin
                    nxt_d.phase = PH_OFFER;
                end
                default: begin
                    nxt_d.phase = PH_IDLE;
                    nxt_d.rings = '0;
                end
            endcase
        end
    end

    assign phase_d = nxt_d.phase;
    assign rings_d = nxt_d.rings;

    // R8: quiet inputs leave the tally untouched
    p_quiet_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!ring_end && !answered) |=> $stable(rings_q) && $stable(phase_q));

    // R6: answer beats a coincident ring
    p_answer_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (answered && ring_end) |=> (phase_q == PH_IDLE) && (rings_q == '0));

    // R2, R3: count never passes the long threshold
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        rings_q <= LONG_T);

endmodule

// File: rtl/pickup_decode.sv
module pickup_decode
    import ans_pkg::*;
(
    input  phase_e phase_q,
    output logic   pickup
);

    always_comb begin
        pickup = (phase_q == PH_OFFER);
    end

endmodule

// File: rtl/ring_answer_ctrl.sv
module ring_answer_ctrl
    import ans_pkg::*;
#(
    parameter int SHORT_RINGS = 2,
    parameter int LONG_RINGS  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ring_end,
    input  logic answered,
    input  logic sel_long,
    output logic pickup
);

    localparam int CW = $clog2(LONG_RINGS + 1);

    phase_e        phase_q, phase_d;
    logic [CW-1:0] rings_q, rings_d;

    ring_tally #(
        .SHORT_RINGS(SHORT_RINGS),
        .LONG_RINGS (LONG_RINGS),
        .CW         (CW)
    ) u_tally (
        .clk     (clk),
        .rst     (rst),
        .phase_q (phase_q),
        .rings_q (rings_q),
        .ring_end(ring_end),
        .answered(answered),
        .sel_long(sel_long),
        .phase_d (phase_d),
        .rings_d (rings_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            rings_q <= '0;
        end else begin
            phase_q <= phase_d;
            rings_q <= rings_d;
        end
    end

    pickup_decode u_decode (
        .phase_q(phase_q),
        .pickup (pickup)
    );

    // R1: reset clears the command
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !pickup);

    // R4: command held while unanswered
    p_hold_until_answer_r4: assert property (@(posedge clk) disable iff (rst)
        (pickup && !answered) |=> pickup);

    // R5: answer drops the command
    p_answer_release_r5: assert property (@(posedge clk) disable iff (rst)
        answered |=> !pickup);

    // R7: a rise needs a counted ring at the previous edge
    p_rise_after_ring_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pickup) |-> ($past(ring_end) && !$past(answered)));

endmodule

// File: tb/sim_ring_answer_ctrl.sv
module sim_ring_answer_ctrl;

    localparam int SHORT_N = 2;
    localparam int LONG_N  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ring_end = 1'b0;
    logic answered = 1'b0;
    logic sel_long = 1'b0;
    logic pickup;

    int n_checks = 0;
    int n_fail   = 0;
    int ref_cnt  = 0;
    bit ref_z    = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ring_answer_ctrl #(.SHORT_RINGS(SHORT_N), .LONG_RINGS(LONG_N)) u0 (
        .clk     (clk),
        .rst     (rst),
        .ring_end(ring_end),
        .answered(answered),
        .sel_long(sel_long),
        .pickup  (pickup)
    );

    task automatic check(input string tag);
        n_checks++;
        if (pickup !== ref_z) begin
            n_fail++;
            $display("FAIL %s: pickup=%0b expected=%0b (t=%0t)", tag, pickup, ref_z, $time);
        end
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(input bit r, input bit a, input bit s, input bit rs, input string tag);
        ring_end = r;
        answered = a;
        sel_long = s;
        rst      = rs;
        @(posedge clk);
        if (rs || a) begin
            ref_cnt = 0;
            ref_z   = 1'b0;
        end else if (!ref_z && r) begin
            ref_cnt++;
            if (ref_cnt >= (s ? LONG_N : SHORT_N)) ref_z = 1'b1;
        end
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        @(negedge clk);
        step(0, 0, 0, 1, "R1 reset");
        step(0, 0, 0, 1, "R1 reset");
        step(0, 0, 0, 0, "R1 idle");

        // short threshold with gaps
        step(1, 0, 0, 0, "R2 first ring");
        step(0, 0, 0, 0, "R8 gap");
        step(0, 0, 0, 0, "R8 gap");
        step(1, 0, 0, 0, "R2 second ring");
        step(1, 0, 0, 0, "R4 extra ring");
        step(0, 0, 0, 0, "R4 hold");
        step(0, 0, 0, 0, "R4 hold");
        step(0, 1, 0, 0, "R5 release");
        step(0, 0, 0, 0, "R5 idle");

        // long threshold
        step(1, 0, 1, 0, "R3 ring1");
        step(0, 0, 1, 0, "R8 gap");
        step(1, 0, 1, 0, "R3 ring2");
        step(1, 0, 1, 0, "R3 ring3");
        step(0, 0, 1, 0, "R8 gap");
        step(1, 0, 1, 0, "R3 ring4");
        step(1, 0, 1, 0, "R4 extra ring");
        step(0, 1, 1, 0, "R5 release");

        // person answers mid-count, long threshold
        step(1, 0, 1, 0, "R3 ring1");
        step(1, 0, 1, 0, "R3 ring2");
        step(0, 1, 1, 0, "R5 mid-count answer");
        step(0, 0, 1, 0, "R5 idle");
        step(1, 0, 1, 0, "R5 recount1");
        step(1, 0, 1, 0, "R5 recount2");
        step(1, 0, 1, 0, "R5 recount3");
        step(1, 0, 1, 0, "R5 recount4");
        step(0, 1, 1, 0, "R5 release");

        // coincident ring and answer, short threshold
        step(1, 0, 0, 0, "R2 ring1");
        step(1, 1, 0, 0, "R6 both high");
        step(1, 0, 0, 0, "R6 counts as first");
        step(0, 0, 0, 0, "R8 gap");
        step(1, 0, 0, 0, "R6 second");
        step(1, 1, 0, 0, "R6 answer with ring");
        step(0, 0, 0, 0, "R7 no rise without ring");

        // reset while offering
        step(1, 0, 0, 0, "R2 ring1");
        step(1, 0, 0, 0, "R2 ring2");
        step(0, 0, 0, 1, "R1 reset in offer");
        step(0, 0, 0, 0, "R7 stays low");
        step(1, 0, 0, 0, "R1 recount");
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: finished=0 expected=1");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule